// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Programmable Antibacklash Overlap

This block compares the rising edges of two divided clocks, a reference clock (the output of the reference divider) and a feedback clock (the output of the feedback divider, whose ratio is B·P + A), and drives the pump-up and pump-down requests toward a charge pump. A rising edge on the reference raises `up`. A rising edge on the feedback raises `dn`. Once both are high, they stay high together for a programmable overlap interval and then fall in the same cycle. Because of this overlap, a loop near lock always gets two short equal pulses and never a gap with no correction, so the transfer function has no dead zone.

All timing is measured in cycles of a fast sampling clock `clk`. Both divided clocks are asynchronous to it. Each passes through a two-flop synchroniser, and a rising edge is found by comparing the synchronised sample with the one from the cycle before. A four-state machine tracks the detector:

- `ST_IDLE`: neither output is high.
- `ST_UP`: only `up` is high.
- `ST_DN`: only `dn` is high.
- `ST_OVL`: both outputs are high and the overlap timer is running.

The transitions are:

- **idle-to-up**: a reference edge alone.
- **idle-to-dn**: a feedback edge alone.
- **idle-to-overlap**: both edges in the same cycle.
- **up-to-overlap**: a feedback edge while in `ST_UP`.
- **dn-to-overlap**: a reference edge while in `ST_DN`.
- **overlap-to-idle**: the timer expires.
- **reset-to-idle**: `rst` is high, from any state.

Top module: `pfd_antibacklash`

## Requirements
- R1: `rst` is synchronous and active high. On the first clock edge at which it is sampled high, the state returns to idle with `up` and `dn` low, and both stay low while it is held.
- R2: A reference rising edge raises `up`. If `ref_clk` is first sampled high at clock edge k, `up` is high after edge k+2.
- R3: A feedback rising edge raises `dn` with the same two-cycle latency as R2.
- R4: Once both outputs are high, they stay high together for exactly L cycles and then fall in the same cycle. L = 2 + 2·`abl_code`, so code 00 gives 2 cycles (the default), 01 gives 4, 10 gives 6 and 11 gives 8.
- R5: `abl_code` is sampled on the clock edge that enters the overlap state. A change to it during the overlap does not alter the length of that overlap.
- R6: When the two edges are detected in the same cycle (equal phase), `up` and `dn` each form one pulse of exactly L cycles.
- R7: When one edge leads the other by d cycles, the leading output forms one pulse of d + L cycles and the lagging output forms one pulse of L cycles.
- R8: A second rising edge on an input whose output is already high, before the other edge arrives, is ignored. The output forms one pulse of the unchanged width.
- R9: A rising edge that arrives during the overlap is ignored. After the overlap ends, both outputs stay low until a new edge arrives.
- R10: Outside reset, `up` and `dn` never fall one without the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; every pulse width is a count of its cycles |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Divided reference clock, asynchronous |
| fb_clk | input | 1 | Divided feedback clock, asynchronous |
| abl_code | input | 2 | Antibacklash overlap select (L = 2 + 2·code cycles) |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |

## Verification
The bench sweeps all four overlap codes against reference-to-feedback offsets from five cycles of feedback lead to five cycles of reference lead, and predicts every pulse width from d + L.

- An off-by-one overlap counter would show up as pulses one cycle too long or too short at every code.
- A detector that clears one flag early would break the paired fall.
- A design that re-armed on an edge during the overlap, or on a repeated edge of an input that is already waiting, would emit a second pulse.
- A timer that read the code live rather than latching it would shorten the pulse when the code changes mid-overlap.

The bench also checks the exact two-cycle input latency and a reset that lands in the middle of an overlap.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2,
        ST_OVL  = 2'd3
    } pfd_state_t;

    // Overlap length in sample cycles for a given code.
    function automatic int unsigned abl_len(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned code);
        return base + step * code;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer
    import pfd_pkg::*;
#(
    parameter int unsigned CODE_W = 2,
    parameter int unsigned BASE   = 2,
    parameter int unsigned STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    output logic              done
);
    localparam int unsigned MAX_LEN = abl_len(BASE, STEP, (1 << CODE_W) - 1);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= '0;
        end else if (start) begin
            cnt <= '0;
            lim <= CNT_W'(abl_len(BASE, STEP, int'(code)) - 1);
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign done = active && (cnt == lim);
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
    import pfd_pkg::*;
#(
    parameter int unsigned CODE_W      = 2,
    parameter int unsigned BASE_LEN    = 2,
    parameter int unsigned STEP_LEN    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              fb_clk,
    input  logic [CODE_W-1:0] abl_code,
    output logic              up,
    output logic              dn
);
    localparam int unsigned N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] edge_seen;
    logic            ref_rise;
    logic            fb_rise;
    logic            ovl_start;
    logic            ovl_done;

    pfd_state_t state_q;
    pfd_state_t state_d;

    assign raw_in = {fb_clk, ref_clk};

    for (genvar g = 0; g < N_IN; g++) begin : g_in
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[g]),
            .rise     (edge_seen[g])
        );
    end

    assign ref_rise = edge_seen[0];
    assign fb_rise  = edge_seen[1];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise && fb_rise) state_d = ST_OVL;
                else if (ref_rise)       state_d = ST_UP;
                else if (fb_rise)        state_d = ST_DN;
            end
            ST_UP:   if (fb_rise)  state_d = ST_OVL;
            ST_DN:   if (ref_rise) state_d = ST_OVL;
            ST_OVL:  if (ovl_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign ovl_start = (state_d == ST_OVL) && (state_q != ST_OVL);

    pfd_abl_timer #(
        .CODE_W (CODE_W),
        .BASE   (BASE_LEN),
        .STEP   (STEP_LEN)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (ovl_start),
        .active (state_q == ST_OVL),
        .code   (abl_code),
        .done   (ovl_done)
    );

    // Output decode
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_UP:   up = 1'b1;
            ST_DN:   dn = 1'b1;
            ST_OVL:  begin up = 1'b1; dn = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/pfd_abl_checker.sv
module pfd_abl_checker
    import pfd_pkg::*;
#(
    parameter int unsigned CODE_W   = 2,
    parameter int unsigned BASE_LEN = 2,
    parameter int unsigned STEP_LEN = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] abl_code,
    input logic              up,
    input logic              dn
);
    localparam int unsigned MAX_LEN = abl_len(BASE_LEN, STEP_LEN, (1 << CODE_W) - 1);
    localparam int unsigned RUN_W   = $clog2(MAX_LEN + 2);

    logic [RUN_W-1:0]  run_q;
    logic              both_q;
    logic              rst_q;
    logic [CODE_W-1:0] code_d;
    logic [CODE_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        code_d <= abl_code;
        if (rst) begin
            run_q  <= '0;
            both_q <= 1'b0;
            lat_q  <= '0;
        end else begin
            both_q <= up && dn;
            run_q  <= (up && dn) ? run_q + 1'b1 : '0;
            if (up && dn && !both_q) lat_q <= code_d;
        end
    end

    // R1: outputs low on the cycle after reset is sampled
    always @(negedge clk) begin
        if (rst_q) begin
            assert_reset_low_R1: assert (!up && !dn);
        end
    end

    // R10: a fall of either output is a fall of both
    assert_paired_fall_R10: assert property (@(posedge clk) disable iff (rst)
        (($fell(up) || $fell(dn)) && !rst_q) |-> (!up && !dn && both_q));

    // R4, R5: overlap length matches the code latched at its start
    assert_overlap_len_R4: assert property (@(posedge clk) disable iff (rst)
        (both_q && !(up && dn) && !rst_q)
        |-> (int'(run_q) == int'(abl_len(BASE_LEN, STEP_LEN, int'(lat_q)))));

    // R4: overlap never exceeds the longest setting
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        int'(run_q) <= int'(MAX_LEN));

    // R9: after an overlap, nothing rises in the very next cycle
    assert_quiet_after_R9: assert property (@(posedge clk) disable iff (rst)
        (both_q && !up && !dn && !rst_q) |=> (!up && !dn));
endmodule

bind pfd_antibacklash pfd_abl_checker #(
    .CODE_W   (CODE_W),
    .BASE_LEN (BASE_LEN),
    .STEP_LEN (STEP_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .abl_code (abl_code),
    .up       (up),
    .dn       (dn)
);

// File: tb/tb_pfd_antibacklash.sv
`timescale 1ns/1ps
module tb_pfd_antibacklash;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_clk = 1'b0;
    logic       fb_clk = 1'b0;
    logic [1:0] abl_code = 2'b00;
    logic       up, dn;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pfd_antibacklash dut (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .fb_clk(fb_clk),
        .abl_code(abl_code), .up(up), .dn(dn)
    );

    function automatic int exp_len(input int code);
        return 2 + 2 * code;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one comparison cycle and measure pulse widths and rise counts.
    task automatic run_pair(input int code, input int code2, input int sw_at,
                            input int dref, input int dfb,
                            input int gs, input int ge,
                            output int upw, output int dnw,
                            output int upr, output int dnr, output int end_hi);
        logic pu, pd;
        upw = 0; dnw = 0; upr = 0; dnr = 0; pu = 0; pd = 0;
        abl_code = 2'(code);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (up) upw++;
            if (dn) dnw++;
            if (up && !pu) upr++;
            if (dn && !pd) dnr++;
            pu = up; pd = dn;
            if (i == sw_at) abl_code = 2'(code2);
            ref_clk = (i >= dref) && (i < 25) && !((i >= gs) && (i < ge));
            fb_clk  = (i >= dfb) && (i < 25);
        end
        end_hi = (up || dn) ? 1 : 0;
        ref_clk = 0; fb_clk = 0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int upw, dnw, upr, dnr, eh, lat;
        repeat (3) @(negedge clk);
        check("R1 reset up", int'(up), 0);
        check("R1 reset dn", int'(dn), 0);
        rst = 0;
        repeat (4) @(negedge clk);

        // R2 / R3 latency
        ref_clk = 1;
        lat = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (up && lat == 0) lat = i;
            if (i <= 5) check("R3 dn idle while only ref", int'(dn), 0);
        end
        check("R2 up latency", lat, 3);
        fb_clk = 1;
        lat = 0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (dn && lat == 0) lat = i;
        end
        check("R3 dn latency", lat, 3);
        repeat (12) @(negedge clk);
        ref_clk = 0; fb_clk = 0;
        repeat (6) @(negedge clk);
        check("R4 cleared after overlap", int'(up || dn), 0);

        // R4 / R6 / R7 sweep over codes and offsets
        for (int c = 0; c < 4; c++) begin
            for (int d = -5; d <= 5; d++) begin
                int dr, df, eu, ed;
                dr = (d < 0) ? -d : 0;
                df = (d > 0) ? d : 0;
                eu = exp_len(c) + ((d > 0) ? d : 0);
                ed = exp_len(c) + ((d < 0) ? -d : 0);
                run_pair(c, c, -1, dr, df, -1, -1, upw, dnw, upr, dnr, eh);
                if (d == 0) begin
                    check("R6 equal phase up width", upw, eu);
                    check("R6 equal phase dn width", dnw, ed);
                end else begin
                    check("R7 lead/lag up width", upw, eu);
                    check("R7 lead/lag dn width", dnw, ed);
                end
                check("R4 single up pulse", upr, 1);
                check("R4 single dn pulse", dnr, 1);
                check("R4 both low at end", eh, 0);
            end
        end

        // R8: repeated ref edge while waiting for feedback
        run_pair(0, 0, -1, 0, 12, 3, 5, upw, dnw, upr, dnr, eh);
        check("R8 up width", upw, 12 + exp_len(0));
        check("R8 up pulse count", upr, 1);
        check("R8 dn width", dnw, exp_len(0));

        // R9: ref edge during the overlap
        run_pair(3, 3, -1, 0, 0, 3, 5, upw, dnw, upr, dnr, eh);
        check("R9 up width", upw, exp_len(3));
        check("R9 up pulse count", upr, 1);
        check("R9 dn pulse count", dnr, 1);

        // R5: code change mid-overlap
        run_pair(3, 0, 6, 0, 0, -1, -1, upw, dnw, upr, dnr, eh);
        check("R5 up width kept", upw, exp_len(3));
        check("R5 dn width kept", dnw, exp_len(3));
        run_pair(0, 3, 4, 0, 0, -1, -1, upw, dnw, upr, dnr, eh);
        check("R5 short width kept", upw, exp_len(0));
        abl_code = 2'b00;

        // R1: reset in the middle of an overlap
        abl_code = 2'b11;
        ref_clk = 1; fb_clk = 1;
        repeat (5) @(negedge clk);
        check("R1 overlap active before reset", int'(up && dn), 1);
        rst = 1; ref_clk = 0; fb_clk = 0;
        @(negedge clk);
        check("R1 up low after reset", int'(up), 0);
        check("R1 dn low after reset", int'(dn), 0);
        @(negedge clk);
        rst = 0;
        eh = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (up || dn) eh = 1;
        end
        check("R1 quiet after reset", eh, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20.0 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule